// File: doc/BRIEF.md
# Downward-Growing Stack Engine with Implicit Add

This block runs a last-in-first-out operand stack that lives in a small single-port data memory. It takes three commands: place a word on the stack, take the top word off and return it, and replace the two top words with their sum. Commands arrive one at a time over a valid/ready handshake, and none of them names an address. The only way into the memory is through a stack pointer that the block owns.

The stack grows toward lower addresses. The pointer always holds the address of the word now on top, and it starts one past the last memory word, so the stack is empty after reset. A push first moves the pointer down and then stores the word there. A pop first reads at the pointer and then moves the pointer up. An add reads two words and writes one, so it keeps the handshake busy while the single memory port is in use. Commands the stack cannot carry out are refused with a one-cycle error pulse, and they change nothing.

Top module: `stk_unit`

## Requirements
- R1: After synchronous reset, cmd_ready is 1, pop_valid, err and carry are 0, and the stack holds no entries.
- R2: cmd_op 0 is PUSH. When the stack is not full, it stores cmd_data as the new top entry in the cycle it is accepted, and cmd_ready stays high.
- R3: cmd_op 1 is POP. It returns the top entry on pop_data, with pop_valid high for exactly one cycle, two cycles after the acceptance cycle. It removes that entry, so successive pops return words in the reverse of push order.
- R4: cmd_op 2 is ADD. It replaces the two top entries with their sum modulo 2^DW, so the stack ends one entry shorter, with the sum on top and the third entry below it.
- R5: carry shows the carry-out of the most recently completed ADD. It changes when an ADD completes and holds at all other times.
- R6: After an ADD is accepted, cmd_ready is low for exactly two cycles and then returns high. After a POP is accepted, cmd_ready is low for exactly one cycle.
- R7: A PUSH while the stack holds 2^AW entries is refused. err is high for one cycle, in the cycle after acceptance, and the stack contents are unchanged.
- R8: A POP on an empty stack is refused with the same err pulse. pop_valid stays low.
- R9: An ADD while the stack holds fewer than two entries is refused with the err pulse, and the stack is unchanged.
- R10: cmd_op 3 is reserved. It is refused with the err pulse and changes no state.
- R11: The stack holds at most 2^AW entries. Exactly that many pushes are accepted from empty before a push is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can accept a command this cycle |
| cmd_op | input | 2 | Command code: 0 push, 1 pop, 2 add, 3 reserved |
| cmd_data | input | DW | Word to push |
| pop_valid | output | 1 | One-cycle strobe marking pop_data |
| pop_data | output | DW | Word removed by a pop |
| carry | output | 1 | Carry-out of the last completed add |
| err | output | 1 | One-cycle pulse: the last accepted command was refused |

## Verification
The stack is tried in four ways. Pushes and pops in matching order show whether the pointer steps down and up in the correct sense. Filling to capacity and draining past empty test both refusal edges. Adds on one or zero entries test the two-operand guard. Operand pairs chosen to overflow and pairs that do not tell a correct carry and wrap apart from an add that keeps bit DW or loses the flag. A long random mix of all four codes, checked against a bench-side stack model, finds pointer drift between the multi-cycle add and the single-cycle push.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_RSVD = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POP  = 2'd1,
    ST_ADDA = 2'd2,
    ST_ADDB = 2'd3
  } stk_st_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/stk_add.sv
module stk_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] full_sum;

  assign full_sum = {1'b0, a} + {1'b0, b};
  assign sum      = full_sum[DW-1:0];
  assign cout     = full_sum[DW];
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          carry,
  output logic          err
);
  localparam int DEPTH = 1 << AW;
  localparam int SPW   = AW + 1;
  localparam logic [SPW-1:0] SP_EMPTY = SPW'(DEPTH);
  localparam logic [SPW-1:0] SP_TWO   = SPW'(DEPTH - 2);

  stk_st_e        st_q;
  logic [SPW-1:0] sp_q;
  logic [DW-1:0]  opa_q;

  logic           ram_we;
  logic [AW-1:0]  ram_addr;
  logic [DW-1:0]  ram_wd;
  logic [DW-1:0]  ram_rd;
  logic [DW-1:0]  sum;
  logic           sum_co;

  stk_op_e        op;
  logic           accept, push_ok, pop_ok, add_ok, reject;
  logic [SPW-1:0] sp_dec, sp_inc;

  assign op        = stk_op_e'(cmd_op);
  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign push_ok   = accept && (op == OP_PUSH) && (sp_q != '0);
  assign pop_ok    = accept && (op == OP_POP)  && (sp_q != SP_EMPTY);
  assign add_ok    = accept && (op == OP_ADD)  && (sp_q <= SP_TWO);
  assign reject    = accept && !(push_ok || pop_ok || add_ok);
  assign sp_dec    = sp_q - 1'b1;
  assign sp_inc    = sp_q + 1'b1;

  stk_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wd),
    .rdata (ram_rd)
  );

  stk_add #(.DW(DW)) u_add (
    .a    (opa_q),
    .b    (ram_rd),
    .sum  (sum),
    .cout (sum_co)
  );

  // one memory access per cycle, selected by state
  always_comb begin
    ram_we   = 1'b0;
    ram_addr = sp_q[AW-1:0];
    ram_wd   = cmd_data;
    unique case (st_q)
      ST_IDLE: if (push_ok) begin
        ram_we   = 1'b1;
        ram_addr = sp_dec[AW-1:0];
      end
      ST_ADDA: ram_addr = sp_inc[AW-1:0];
      ST_ADDB: begin
        ram_we   = 1'b1;
        ram_addr = sp_inc[AW-1:0];
        ram_wd   = sum;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      sp_q      <= SP_EMPTY;
      opa_q     <= '0;
      pop_valid <= 1'b0;
      pop_data  <= '0;
      carry     <= 1'b0;
      err       <= 1'b0;
    end else begin
      err       <= reject;
      pop_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (push_ok) sp_q <= sp_dec;
          if (pop_ok)  st_q <= ST_POP;
          if (add_ok)  st_q <= ST_ADDA;
        end
        ST_POP: begin
          pop_data  <= ram_rd;
          pop_valid <= 1'b1;
          sp_q      <= sp_inc;
          st_q      <= ST_IDLE;
        end
        ST_ADDA: begin
          opa_q <= ram_rd;
          st_q  <= ST_ADDB;
        end
        ST_ADDB: begin
          carry <= sum_co;
          sp_q  <= sp_inc;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic          pop_valid,
  input logic          err,
  input logic [AW:0]   sp_q
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] SP_EMPTY = (AW+1)'(DEPTH);
  localparam logic [AW:0] SP_TWO   = (AW+1)'(DEPTH - 2);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (sp_q == SP_EMPTY) && cmd_ready && !err && !pop_valid);

  // R3
  pop_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |=> !pop_valid);

  // R3
  pop_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'd1 && sp_q != SP_EMPTY) |=> !pop_valid ##1 pop_valid);

  // R6
  add_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'd2 && sp_q <= SP_TWO) |=> !cmd_ready ##1 !cmd_ready ##1 cmd_ready);

  // R7
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'd0 && sp_q == '0) |=> err && $stable(sp_q));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == 2'd1 && sp_q == SP_EMPTY) |=> err && !pop_valid && cmd_ready);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R11
  sp_range_chk: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SP_EMPTY);
endmodule

bind stk_unit stk_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .pop_valid (pop_valid),
  .err       (err),
  .sp_q      (sp_q)
);

// File: tb/test_stk_unit.sv
module test_stk_unit;
  localparam int DW    = 8;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [DW-1:0] cmd_data = '0;
  logic          pop_valid;
  logic [DW-1:0] pop_data;
  logic          carry;
  logic          err;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [DW-1:0] mstk [DEPTH];
  int            mcnt = 0;
  logic          mcarry = 1'b0;

  always #10 clk = ~clk;

  stk_unit #(.DW(DW), .AW(AW)) i_stk_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .pop_valid(pop_valid),
    .pop_data(pop_data), .carry(carry), .err(err)
  );

  function automatic logic [DW:0] exp_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic bit legal(input logic [1:0] op);
    case (op)
      2'd0:    return mcnt < DEPTH;
      2'd1:    return mcnt > 0;
      2'd2:    return mcnt >= 2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] op, input bit ok);
    case (op)
      2'd0:    return ok ? "R2" : "R7";
      2'd1:    return ok ? "R3" : "R8";
      2'd2:    return ok ? "R4" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [DW-1:0] d);
    bit ok;
    string rq;
    logic [DW:0] s;
    ok = legal(op);
    rq = req_of(op, ok);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({rq, " err"}, int'(err), int'(!ok));
    chk({rq, " ready+1 (R6)"}, int'(cmd_ready), int'(!(ok && op != 2'd0)));
    chk({rq, " no early pop_valid"}, int'(pop_valid), 0);
    @(negedge clk);
    chk({rq, " err pulse"}, int'(err), 0);
    if (ok && op == 2'd1) begin
      chk("R3 pop_valid", int'(pop_valid), 1);
      chk("R3 pop_data LIFO", int'(pop_data), int'(mstk[mcnt-1]));
    end else begin
      chk({rq, " pop_valid quiet"}, int'(pop_valid), 0);
    end
    chk("R6 ready+2", int'(cmd_ready), int'(!(ok && op == 2'd2)));
    if (ok && op == 2'd2) begin
      s = exp_add(mstk[mcnt-1], mstk[mcnt-2]);
      @(negedge clk);
      chk("R6 ready back", int'(cmd_ready), 1);
      chk("R5 carry", int'(carry), int'(s[DW]));
      mcarry = s[DW];
      mcnt--;
      mstk[mcnt-1] = s[DW-1:0];
    end else begin
      chk("R5 carry held", int'(carry), int'(mcarry));
      if (ok && op == 2'd0) begin
        mstk[mcnt] = d;
        mcnt++;
      end else if (ok && op == 2'd1) begin
        mcnt--;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 pop_valid", int'(pop_valid), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 carry", int'(carry), 0);
    // R1 / R8: empty after reset
    do_cmd(2'd1, '0);
    // R9: add with zero and one entry
    do_cmd(2'd2, '0);
    do_cmd(2'd0, 8'h5A);
    do_cmd(2'd2, '0);
    // R10 reserved code
    do_cmd(2'd3, 8'hFF);
    do_cmd(2'd1, '0);
    // R11 capacity then R7 overflow refusal
    for (int i = 0; i < DEPTH; i++) do_cmd(2'd0, DW'(8'h10 + i));
    chk("R11 count", mcnt, DEPTH);
    do_cmd(2'd0, 8'hEE);
    // R3 drain in reverse order, R8 past empty
    for (int i = 0; i < DEPTH + 1; i++) do_cmd(2'd1, '0);
    // R4 / R5: wrap with carry, then no carry
    do_cmd(2'd0, 8'h33);
    do_cmd(2'd0, 8'hF0);
    do_cmd(2'd0, 8'h20);
    do_cmd(2'd2, '0);
    do_cmd(2'd0, 8'h01);
    do_cmd(2'd0, 8'h02);
    do_cmd(2'd2, '0);
    do_cmd(2'd2, '0);
    do_cmd(2'd2, '0);
    do_cmd(2'd1, '0);
    do_cmd(2'd1, '0);
    // random mix against the model
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      logic [1:0] op;
      r = $urandom % 16;
      op = (r < 6) ? 2'd0 : (r < 11) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
      do_cmd(op, DW'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule